// File: doc/BRIEF.md
# Core-Local Timer and Software-Interrupt Unit

This unit sits beside a single processor core and generates its two machine-level local interrupt requests. One request comes from a software-controlled pending bit. The other comes from comparing a 64-bit free-running time count against a 64-bit compare value. Software reaches all of this state through a small memory-mapped register window. The window occupies a 64 KiB region whose base is a parameter, 0x0200_0000 by default.

The register port is a valid/ready request bus that is always ready. Each request carries a byte address, 64-bit write data and eight byte strobes. Every accepted request is answered one cycle later on the response side. Byte lanes follow the address: lanes 0–3 hold the lower word of an aligned doubleword and lanes 4–7 hold the upper word. A 32-bit core can therefore write the compare value as two separate words. A 64-bit core can write it in one access.

The time count advances on each cycle in which the tick enable input is high. Software arms the timer by writing a compare value. It withdraws a pending timer request by writing a value that lies far in the future.

Top module: `core_irq_unit`

## Requirements
- R1: After reset, sw_irq and tmr_irq are 0, the time count reads 0 and the compare value reads all ones.
- R2: A write to offset 0x0000 with strobe bit 0 set loads bit 0 of the write data into the software pending bit, which drives sw_irq from the next cycle. A read at offset 0x0000 returns that bit in data bit 0, with all other bits 0.
- R3: tmr_irq is high exactly when the time count is greater than or equal to the compare value, using an unsigned 64-bit comparison. Equality counts as high.
- R4: The compare value sits at offset 0x4000. Strobes 0–3 write its low 32 bits from data bits 31:0, reachable by a 32-bit write at 0x4000. Strobes 4–7 write its high 32 bits from data bits 63:32, reachable by a 32-bit write at 0x4004. Bytes whose strobe is clear keep their value. A read at 0x4000 or 0x4004 returns the full 64-bit value.
- R5: Writing zero to the compare value raises tmr_irq in the cycle after the write. Writing all ones withdraws it in the cycle after the write.
- R6: The time count rises by exactly one on each clock edge at which tick_en is high and holds otherwise. It is read at offset 0xBFF8, and writes to that offset are ignored.
- R7: Any other offset, and any address outside the base window, reads as zero. Writes there change no state.
- R8: req_ready is always 1. rsp_valid is high exactly in the cycle after each accepted request. rsp_rdata is zero for write responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_en | input | 1 | Time count advance enable |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 64 | Write data, lane-aligned |
| req_wstrb | input | 8 | Byte write strobes |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 64 | Read data |
| sw_irq | output | 1 | Machine software interrupt request |
| tmr_irq | output | 1 | Machine timer interrupt request |

## Verification
The bench builds the unit with its defaults: base 0x0200_0000 and 64-bit time and data widths. With those values the all-ones reset compare value and the split writes of the upper and lower halves are exercised in their real positions. The small counts the bench can tick through still reach the equality boundary of the compare. A write just outside the base window shows that the high address bits are decoded. Wrap of the 64-bit time count lies out of reach at this width.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;

    typedef enum logic [1:0] {
        RGN_NONE,
        RGN_SWI,
        RGN_CMP,
        RGN_TIME
    } region_e;

    localparam int WIN_W = 16;
    localparam logic [WIN_W-1:0] OFS_SWI  = 16'h0000;
    localparam logic [WIN_W-1:0] OFS_CMP  = 16'h4000;
    localparam logic [WIN_W-1:0] OFS_TIME = 16'hBFF8;

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import irq_unit_pkg::*;
#(
    parameter int                ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE   = 32'h0200_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);
    localparam int DW_LSB = 3;

    logic in_window;

    always_comb begin
        in_window = (addr[ADDR_W-1:WIN_W] == BASE[ADDR_W-1:WIN_W]);
        region    = RGN_NONE;
        if (in_window) begin
            case (addr[WIN_W-1:DW_LSB])
                OFS_SWI[WIN_W-1:DW_LSB]:  region = RGN_SWI;
                OFS_CMP[WIN_W-1:DW_LSB]:  region = RGN_CMP;
                OFS_TIME[WIN_W-1:DW_LSB]: region = RGN_TIME;
                default:                  region = RGN_NONE;
            endcase
        end
    end
endmodule

// File: rtl/irq_time_base.sv
module irq_time_base #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    output logic [TIME_W-1:0] time_val
);
    typedef struct packed {
        logic [TIME_W-1:0] count;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_en) begin
            st_d.count = st_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign time_val = st_q.count;
endmodule

// File: rtl/irq_cmp_reg.sv
module irq_cmp_reg #(
    parameter int TIME_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [TIME_W-1:0]   wdata,
    input  logic [TIME_W/8-1:0] wstrb,
    input  logic [TIME_W-1:0]   time_val,
    output logic [TIME_W-1:0]   cmp_val,
    output logic                tmr_irq
);
    localparam int NBYTES = TIME_W / 8;

    typedef struct packed {
        logic [TIME_W-1:0] cmp;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic [TIME_W-1:0] merged;

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign merged[8*b +: 8] = wstrb[b] ? wdata[8*b +: 8] : st_q.cmp[8*b +: 8];
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cmp = merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cmp <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_val = st_q.cmp;
    assign tmr_irq = (time_val >= st_q.cmp);
endmodule

// File: rtl/core_irq_unit.sv
module core_irq_unit
    import irq_unit_pkg::*;
#(
    parameter int          ADDR_W = 32,
    parameter int          DATA_W = 64,
    parameter logic [31:0] BASE   = 32'h0200_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_wstrb,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                sw_irq,
    output logic                tmr_irq
);
    localparam int TIME_W = DATA_W;

    typedef struct packed {
        logic              sw;
        logic              rsp_v;
        logic [DATA_W-1:0] rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    region_e           region;
    logic [TIME_W-1:0] time_val;
    logic [TIME_W-1:0] cmp_val;
    logic              cmp_wr;

    irq_addr_decode #(
        .ADDR_W (ADDR_W),
        .BASE   (BASE[ADDR_W-1:0])
    ) u_dec (
        .addr   (req_addr),
        .region (region)
    );

    irq_time_base #(
        .TIME_W (TIME_W)
    ) u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .time_val (time_val)
    );

    assign cmp_wr = req_valid && req_write && (region == RGN_CMP);

    irq_cmp_reg #(
        .TIME_W (TIME_W)
    ) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cmp_wr),
        .wdata    (req_wdata),
        .wstrb    (req_wstrb),
        .time_val (time_val),
        .cmp_val  (cmp_val),
        .tmr_irq  (tmr_irq)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rsp_v = req_valid;
        st_d.rdata = '0;
        if (req_valid) begin
            if (req_write) begin
                if (region == RGN_SWI && req_wstrb[0]) begin
                    st_d.sw = req_wdata[0];
                end
            end else begin
                case (region)
                    RGN_SWI:  st_d.rdata = {{(DATA_W-1){1'b0}}, st_q.sw};
                    RGN_CMP:  st_d.rdata = cmp_val;
                    RGN_TIME: st_d.rdata = time_val;
                    default:  st_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = 1'b1;
    assign rsp_valid = st_q.rsp_v;
    assign rsp_rdata = st_q.rdata;
    assign sw_irq    = st_q.sw;
endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk #(
    parameter logic [31:0] BASE = 32'h0200_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_en,
    input logic        req_valid,
    input logic        req_write,
    input logic [31:0] req_addr,
    input logic [63:0] req_wdata,
    input logic [7:0]  req_wstrb,
    input logic        rsp_valid,
    input logic        sw_irq,
    input logic        tmr_irq,
    input logic [63:0] time_val,
    input logic [63:0] cmp_val
);
    logic hit_swi, in_win, known;

    always_comb begin
        hit_swi = (req_addr[31:3] == BASE[31:3]);
        in_win  = (req_addr[31:16] == BASE[31:16]);
        known   = in_win && ((req_addr[15:3] == 13'h0000) ||
                             (req_addr[15:3] == 13'h0800) ||
                             (req_addr[15:3] == 13'h17FF));
    end

    // R6
    time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> time_val == $past(time_val) + 64'd1);

    // R6
    time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> time_val == $past(time_val));

    // R3
    cmp_relation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_irq == (time_val >= cmp_val));

    // R2
    swi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && hit_swi && req_wstrb[0]) |=> sw_irq == $past(req_wdata[0]));

    // R8
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R8
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R7
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !known) |=> ($stable(cmp_val) && $stable(sw_irq)));
endmodule

bind core_irq_unit irq_unit_chk #(.BASE(BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_wstrb (req_wstrb),
    .rsp_valid (rsp_valid),
    .sw_irq    (sw_irq),
    .tmr_irq   (tmr_irq),
    .time_val  (time_val),
    .cmp_val   (cmp_val)
);

// File: tb/tb_core_irq_unit.sv
module tb_core_irq_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] B = 32'h0200_0000;

    typedef struct packed {
        logic [3:0]  rq;
        logic        we;
        logic [31:0] addr;
        logic [63:0] wdata;
        logic [7:0]  strb;
        logic [63:0] exp_rd;
        logic        exp_sw;
        logic        exp_tmr;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{4'd2, 1'b1, B + 32'h0000, 64'h1,                  8'h0F, 64'h0,                  1'b1, 1'b0},
        '{4'd2, 1'b0, B + 32'h0000, 64'h0,                  8'h00, 64'h1,                  1'b1, 1'b0},
        '{4'd2, 1'b1, B + 32'h0000, 64'h0,                  8'h0F, 64'h0,                  1'b0, 1'b0},
        '{4'd4, 1'b1, B + 32'h4000, 64'h0,                  8'h0F, 64'h0,                  1'b0, 1'b0},
        '{4'd4, 1'b0, B + 32'h4000, 64'h0,                  8'h00, 64'hFFFFFFFF_00000000,  1'b0, 1'b0},
        '{4'd5, 1'b1, B + 32'h4004, 64'h0,                  8'hF0, 64'h0,                  1'b0, 1'b1},
        '{4'd5, 1'b1, B + 32'h4000, 64'hFFFFFFFF_FFFFFFFF,  8'hFF, 64'h0,                  1'b0, 1'b0},
        '{4'd4, 1'b0, B + 32'h4004, 64'h0,                  8'h00, 64'hFFFFFFFF_FFFFFFFF,  1'b0, 1'b0},
        '{4'd7, 1'b1, B + 32'h1000, 64'hFFFFFFFF_FFFFFFFF,  8'hFF, 64'h0,                  1'b0, 1'b0},
        '{4'd7, 1'b0, B + 32'h1000, 64'h0,                  8'h00, 64'h0,                  1'b0, 1'b0},
        '{4'd7, 1'b1, 32'h0300_0000, 64'h1,                 8'hFF, 64'h0,                  1'b0, 1'b0},
        '{4'd6, 1'b0, B + 32'hBFF8, 64'h0,                  8'h00, 64'h0,                  1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [7:0]  req_wstrb = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        sw_irq;
    logic        tmr_irq;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    core_irq_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_wstrb (req_wstrb),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .sw_irq    (sw_irq),
        .tmr_irq   (tmr_irq)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic we, input logic [31:0] a, input logic [63:0] d,
                          input logic [7:0] s);
        @(negedge clk);
        check("R8 ready", {63'b0, req_ready}, 64'h1);
        req_valid = 1'b1;
        req_write = we;
        req_addr  = a;
        req_wdata = d;
        req_wstrb = s;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        check("R8 rsp_valid", {63'b0, rsp_valid}, 64'h1);
    endtask

    task automatic rd(input string tag, input logic [31:0] a, input logic [63:0] exp);
        do_req(1'b0, a, 64'h0, 8'h00);
        check(tag, rsp_rdata, exp);
    endtask

    task automatic wr(input logic [31:0] a, input logic [63:0] d, input logic [7:0] s);
        do_req(1'b1, a, d, s);
        check("R8 write rdata zero", rsp_rdata, 64'h0);
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 sw_irq", {63'b0, sw_irq}, 64'h0);
        check("R1 tmr_irq", {63'b0, tmr_irq}, 64'h0);
        check("R8 idle rsp", {63'b0, rsp_valid}, 64'h0);
        rd("R1 compare reset", B + 32'h4000, 64'hFFFFFFFF_FFFFFFFF);
        rd("R1 time reset", B + 32'hBFF8, 64'h0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i].rq, i);
            do_req(VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].strb);
            check({tag, " rdata"}, rsp_rdata, VECS[i].exp_rd);
            check({tag, " sw_irq"}, {63'b0, sw_irq}, {63'b0, VECS[i].exp_sw});
            check({tag, " tmr_irq"}, {63'b0, tmr_irq}, {63'b0, VECS[i].exp_tmr});
        end

        // R6 counting and hold
        tick(10);
        rd("R6 time after 10", B + 32'hBFF8, 64'd10);
        repeat (5) @(posedge clk);
        rd("R6 time held", B + 32'hBFF8, 64'd10);
        wr(B + 32'hBFF8, 64'h0, 8'hFF);
        rd("R6 time write ignored", B + 32'hBFF8, 64'd10);

        // R3 equality boundary
        wr(B + 32'h4000, 64'd15, 8'hFF);
        check("R3 below", {63'b0, tmr_irq}, 64'h0);
        tick(4);
        check("R3 one below", {63'b0, tmr_irq}, 64'h0);
        tick(1);
        check("R3 equal", {63'b0, tmr_irq}, 64'h1);
        tick(2);
        check("R3 above", {63'b0, tmr_irq}, 64'h1);
        wr(B + 32'h4000, 64'hFFFFFFFF_FFFFFFFF, 8'hFF);
        check("R5 withdraw", {63'b0, tmr_irq}, 64'h0);

        // R4 split halves, high first then low
        wr(B + 32'h4004, 64'h0, 8'hF0);
        check("R4 high half only", {63'b0, tmr_irq}, 64'h0);
        rd("R4 readback high", B + 32'h4000, 64'h00000000_FFFFFFFF);
        wr(B + 32'h4000, 64'hAAAAAAAA_00000010, 8'h0F);
        rd("R4 readback low", B + 32'h4000, 64'h00000000_00000010);
        check("R4 armed", {63'b0, tmr_irq}, 64'h1);

        // R5 zero fires promptly
        wr(B + 32'h4000, 64'hFFFFFFFF_FFFFFFFF, 8'hFF);
        wr(B + 32'h4000, 64'h0, 8'hFF);
        check("R5 zero fires", {63'b0, tmr_irq}, 64'h1);

        // R2 strobe bit 0 clear leaves pending bit
        wr(B, 64'h1, 8'h01);
        wr(B, 64'h0, 8'h0E);
        check("R2 no strobe keep", {63'b0, sw_irq}, 64'h1);

        finish_run();
    end
endmodule